// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of address-segment descriptors. It sits next to an address translation unit. Each slot holds two 64-bit words: a tag word and a descriptor word. The tag word carries the effective segment number and a valid flag. The descriptor word carries a segment-size field and payload that later stages use.

A requester presents one operation per cycle. The operation is one of the following:

- an associative search by effective address,
- a store into a numbered slot,
- a read of either word of a numbered slot,
- a clear of the one entry that matches an address,
- a clear of every slot except slot 0.

Each slot matches at its own granularity, either 256 MB or 1 TB, as chosen by its size field. Results come back on the next clock edge with a done strobe and an error flag. When an invalidation actually removes a live entry, a one-cycle pulse tells a downstream translation cache to flush.

Top module: `slb_array`

## Requirements
- R1: While reset is high, and on the cycle after it falls, every output is 0. Reset leaves every slot with an all-zero tag and descriptor, so lookups miss and reads return 0.
- R2: The operation codes are 0 lookup, 1 store, 2 read tag, 3 read descriptor, 4 invalidate-one and 5 invalidate-all. A request raises rsp_done exactly one cycle later, and rsp_done stays low after a cycle with no request. Codes 6 and 7 return rsp_err with no other effect.
- R3: The tag word holds the segment number in bits 63:28 and the valid flag in bit 27. The descriptor size field is bits 63:62, where 00 means 256 MB and 01 means 1 TB. An entry of size 00 hits when its tag equals address bits 63:28 with bit 27 set and all other bits zero. A lookup hit returns rsp_hit, the slot and the descriptor word. A miss returns hit 0, slot 0 and data 0.
- R4: An entry of size 01 hits only when its tag equals address bits 63:40 with bit 27 set and all other bits zero. Each compare counts only for its own size code.
- R5: When several slots hit, the lowest-numbered slot is reported.
- R6: A store takes its slot from address bits 11:0. If any bit of that field at or above log2(ENTRIES) is set, the store returns rsp_err and writes nothing.
- R7: A store returns rsp_err and writes nothing in two cases: the size field is 10 or 11, or the size field is 01 while large_seg_ok is low.
- R8: An accepted store writes the address masked to bits 63:27 as the tag word and writes the data operand unchanged as the descriptor word. The response carries rsp_slot equal to the slot number, data 0 and no error.
- R9: A read of either word uses address bits 11:0 as the slot and returns the stored word. If the slot is not below ENTRIES, the read returns rsp_err with data 0.
- R10: Invalidate-all clears bit 27 of every slot except slot 0.
- R11: Invalidate-all pulses tlb_flush together with rsp_done only if at least one valid bit was cleared.
- R12: Invalidate-one searches as a lookup does. On a hit it clears that slot's bit 27, pulses tlb_flush and reports hit and slot. On a miss it changes nothing and does not pulse.
- R13: tlb_flush is high only in the response cycle of an invalidate operation, and never together with rsp_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 64 | Effective address or slot operand |
| req_wdata | input | 64 | Descriptor word for a store |
| large_seg_ok | input | 1 | Permits 1 TB entries to be stored |
| rsp_done | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Request rejected |
| rsp_hit | output | 1 | Search found an entry |
| rsp_slot | output | log2(ENTRIES) | Matching or addressed slot |
| rsp_data | output | 64 | Descriptor or read word |
| tlb_flush | output | 1 | One-cycle flush request downstream |

## Verification
The assertions assume that every request lasts exactly one cycle. They also assume that req_op, req_addr, req_wdata and large_seg_ok are known whenever req_valid is high, and that large_seg_ok does not change in the cycle a store is sampled. The stimulus meets these assumptions by driving every input only on falling edges and holding each value for a full period. Requests run back-to-back or are separated by idle cycles. Stimulus also covers the operand patterns that separate the two match granularities: a tag with bits 39:28 nonzero on a 1 TB entry, a 256 MB-style tag on a 1 TB entry, and duplicate tags in several slots.

// File: rtl/slb_pkg.sv
package slb_pkg;

    localparam int WORD_W       = 64;
    localparam int SLOT_FIELD_W = 12;
    localparam int VALID_POS    = 27;
    localparam int SEG_LO_SMALL = 28;
    localparam int SEG_LO_LARGE = 40;
    localparam int SIZE_HI      = 63;
    localparam int SIZE_LO      = 62;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_LOOKUP  = 3'd0,
        OP_STORE   = 3'd1,
        OP_RD_TAG  = 3'd2,
        OP_RD_DESC = 3'd3,
        OP_INV_ONE = 3'd4,
        OP_INV_ALL = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SZ_SMALL = 2'b00,
        SZ_LARGE = 2'b01,
        SZ_RSV2  = 2'b10,
        SZ_RSV3  = 2'b11
    } seg_size_e;

    typedef struct packed {
        logic  done;
        logic  err;
        logic  hit;
        logic  flush;
        word_t data;
    } rsp_t;

    // Search key: segment bits above 'lo' kept, valid flag forced on.
    function automatic word_t seg_key(word_t ea, int unsigned lo);
        return (ea & (~word_t'(0) << lo)) | (word_t'(1) << VALID_POS);
    endfunction

    // Tag word as written by a store: segment number and valid flag only.
    function automatic word_t tag_of_store(word_t operand);
        return operand & ((~word_t'(0) << SEG_LO_SMALL) | (word_t'(1) << VALID_POS));
    endfunction

    function automatic seg_size_e size_of(word_t desc);
        return seg_size_e'(desc[SIZE_HI:SIZE_LO]);
    endfunction

endpackage

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
(
    input  word_t ea,
    input  word_t tag,
    input  word_t desc,
    output logic  hit
);
    always_comb begin
        case (size_of(desc))
            SZ_SMALL: hit = (tag == seg_key(ea, SEG_LO_SMALL));
            SZ_LARGE: hit = (tag == seg_key(ea, SEG_LO_LARGE));
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/slb_prio.sv
module slb_prio #(
    parameter int N  = 16,
    parameter int SW = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [SW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = SW'(i);
        end
    end
endmodule

// File: rtl/slb_entries.sv
module slb_entries
    import slb_pkg::*;
#(
    parameter int N  = 16,
    parameter int SW = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_idx,
    input  word_t               wr_tag,
    input  word_t               wr_desc,
    input  logic [N-1:0]        clr,
    output word_t [N-1:0]       tag_q,
    output word_t [N-1:0]       desc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            desc_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && (wr_idx == SW'(i))) begin
                    tag_q[i]  <= wr_tag;
                    desc_q[i] <= wr_desc;
                end else if (clr[i]) begin
                    tag_q[i][VALID_POS] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/slb_array.sv
module slb_array
    import slb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [2:0]                   req_op,
    input  logic [63:0]                  req_addr,
    input  logic [63:0]                  req_wdata,
    input  logic                         large_seg_ok,
    output logic                         rsp_done,
    output logic                         rsp_err,
    output logic                         rsp_hit,
    output logic [$clog2(ENTRIES)-1:0]   rsp_slot,
    output logic [63:0]                  rsp_data,
    output logic                         tlb_flush
);
    localparam int SLOT_W = $clog2(ENTRIES);
    localparam logic [SLOT_FIELD_W-1:0] HIGH_MASK =
        SLOT_FIELD_W'((1 << SLOT_FIELD_W) - ENTRIES);

    word_t [ENTRIES-1:0] tag_w;
    word_t [ENTRIES-1:0] desc_w;
    logic  [ENTRIES-1:0] match_vec;
    logic  [ENTRIES-1:0] live_vec;
    logic  [ENTRIES-1:0] clr_vec;
    logic                hit_any;
    logic  [SLOT_W-1:0]  hit_idx;

    logic [SLOT_FIELD_W-1:0] slot_field;
    logic [SLOT_W-1:0]       slot_idx;
    logic                    slot_bad;
    seg_size_e               wr_size;
    logic                    wr_en;

    rsp_t              nxt, rsp_q;
    logic [SLOT_W-1:0] nxt_slot, slot_q;

    slb_entries #(.N(ENTRIES), .SW(SLOT_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (slot_idx),
        .wr_tag  (tag_of_store(req_addr)),
        .wr_desc (req_wdata),
        .clr     (clr_vec),
        .tag_q   (tag_w),
        .desc_q  (desc_w)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        slb_match u_cmp (
            .ea   (req_addr),
            .tag  (tag_w[g]),
            .desc (desc_w[g]),
            .hit  (match_vec[g])
        );
        assign live_vec[g] = tag_w[g][VALID_POS];
    end

    slb_prio #(.N(ENTRIES), .SW(SLOT_W)) u_prio (
        .req (match_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    assign slot_field = req_addr[SLOT_FIELD_W-1:0];
    assign slot_idx   = slot_field[SLOT_W-1:0];
    assign slot_bad   = |(slot_field & HIGH_MASK);
    assign wr_size    = size_of(req_wdata);

    always_comb begin
        nxt      = '0;
        nxt_slot = '0;
        wr_en    = 1'b0;
        clr_vec  = '0;
        if (req_valid) begin
            nxt.done = 1'b1;
            case (req_op)
                OP_LOOKUP: begin
                    nxt.hit  = hit_any;
                    nxt_slot = hit_any ? hit_idx : '0;
                    nxt.data = hit_any ? desc_w[hit_idx] : '0;
                end
                OP_STORE: begin
                    nxt_slot = slot_idx;
                    nxt.err  = slot_bad
                             || (wr_size == SZ_RSV2) || (wr_size == SZ_RSV3)
                             || ((wr_size == SZ_LARGE) && !large_seg_ok);
                    wr_en    = !nxt.err;
                end
                OP_RD_TAG, OP_RD_DESC: begin
                    nxt_slot = slot_idx;
                    nxt.err  = slot_bad;
                    if (!slot_bad) begin
                        nxt.data = (req_op == OP_RD_TAG) ? tag_w[slot_idx]
                                                         : desc_w[slot_idx];
                    end
                end
                OP_INV_ONE: begin
                    if (hit_any) begin
                        nxt.hit           = 1'b1;
                        nxt_slot          = hit_idx;
                        nxt.flush         = 1'b1;
                        clr_vec[hit_idx]  = 1'b1;
                    end
                end
                OP_INV_ALL: begin
                    clr_vec    = live_vec & ~ENTRIES'(1);
                    nxt.flush  = |clr_vec;
                end
                default: nxt.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= '0;
            slot_q <= '0;
        end else begin
            rsp_q  <= nxt;
            slot_q <= nxt_slot;
        end
    end

    assign rsp_done  = rsp_q.done;
    assign rsp_err   = rsp_q.err;
    assign rsp_hit   = rsp_q.hit;
    assign tlb_flush = rsp_q.flush;
    assign rsp_data  = rsp_q.data;
    assign rsp_slot  = slot_q;

endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk #(
    parameter int ENTRIES = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic [2:0]                 req_op,
    input logic [63:0]                req_addr,
    input logic [63:0]                req_wdata,
    input logic                       large_seg_ok,
    input logic                       rsp_done,
    input logic                       rsp_err,
    input logic                       rsp_hit,
    input logic [$clog2(ENTRIES)-1:0] rsp_slot,
    input logic [63:0]                rsp_data,
    input logic                       tlb_flush
);
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done); // R2
    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done && !tlb_flush); // R2
    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op > 3'd5) |=> rsp_err && !rsp_hit); // R2
    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> !rsp_err && rsp_done); // R3
    AST_STORE_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1 && req_addr[11:0] >= 12'(ENTRIES)) |=> rsp_err); // R6
    AST_STORE_SIZE_CODE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1 && (req_wdata[63]
            || (req_wdata[63:62] == 2'b01 && !large_seg_ok))) |=> rsp_err); // R7
    AST_READ_RANGE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 3'd2 || req_op == 3'd3) && req_addr[11:0] >= 12'(ENTRIES))
            |=> rsp_err && rsp_data == 64'd0); // R9
    AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (rst)
        tlb_flush |-> $past(req_valid) && ($past(req_op) == 3'd4 || $past(req_op) == 3'd5)); // R13
    AST_FLUSH_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        tlb_flush |-> !rsp_err); // R13
    AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid) && $past(req_op) == 3'd0 && !rsp_hit) |-> rsp_data == 64'd0); // R3
endmodule

bind slb_array slb_array_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .large_seg_ok (large_seg_ok),
    .rsp_done     (rsp_done),
    .rsp_err      (rsp_err),
    .rsp_hit      (rsp_hit),
    .rsp_slot     (rsp_slot),
    .rsp_data     (rsp_data),
    .tlb_flush    (tlb_flush)
);

// File: tb/slb_array_test.sv
module slb_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [63:0]   req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          large_seg_ok = 1'b0;
    logic          rsp_done, rsp_err, rsp_hit, tlb_flush;
    logic [SW-1:0] rsp_slot;
    logic [63:0]   rsp_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic [63:0] m_tag  [N];
    logic [63:0] m_desc [N];

    slb_array #(.ENTRIES(N)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .large_seg_ok(large_seg_ok),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_hit(rsp_hit),
        .rsp_slot(rsp_slot), .rsp_data(rsp_data), .tlb_flush(tlb_flush)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cmp(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic d, input logic e,
                             input logic h, input int s, input logic [63:0] dat,
                             input logic f);
        cmp(tag, "done",  64'(rsp_done),  64'(d));
        cmp(tag, "err",   64'(rsp_err),   64'(e));
        cmp(tag, "hit",   64'(rsp_hit),   64'(h));
        cmp(tag, "slot",  64'(rsp_slot),  64'(s));
        cmp(tag, "data",  rsp_data,       dat);
        cmp(tag, "flush", 64'(tlb_flush), 64'(f));
    endtask

    function automatic void model_find(input logic [63:0] a, output logic h, output int s);
        h = 1'b0;
        s = 0;
        for (int i = 0; i < N; i++) begin
            logic [63:0] k_small, k_large;
            k_small = {a[63:28], 1'b1, 27'd0};
            k_large = {a[63:40], 12'd0, 1'b1, 27'd0};
            if (!h && ((m_desc[i][63:62] == 2'b00 && m_tag[i] == k_small) ||
                       (m_desc[i][63:62] == 2'b01 && m_tag[i] == k_large))) begin
                h = 1'b1;
                s = i;
            end
        end
    endfunction

    task automatic do_op(input logic [2:0] op, input logic [63:0] a,
                         input logic [63:0] d, input string tag);
        logic e_err, e_hit, e_flush, h;
        logic [63:0] e_data;
        int e_slot, hs, sl;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        e_err = 0; e_hit = 0; e_flush = 0; e_data = 0; e_slot = 0;
        sl = int'(a[11:0]);
        case (op)
            3'd0: begin
                model_find(a, h, hs);
                if (h) begin e_hit = 1; e_slot = hs; e_data = m_desc[hs]; end
            end
            3'd1: begin
                e_slot = sl % N;
                e_err = (sl >= N) || d[63] || (d[63:62] == 2'b01 && !large_seg_ok);
                if (!e_err) begin
                    m_tag[sl]  = a & 64'hFFFF_FFFF_F800_0000;
                    m_desc[sl] = d;
                end
            end
            3'd2, 3'd3: begin
                e_slot = sl % N;
                e_err = (sl >= N);
                if (!e_err) e_data = (op == 3'd2) ? m_tag[sl] : m_desc[sl];
            end
            3'd4: begin
                model_find(a, h, hs);
                if (h) begin
                    e_hit = 1; e_slot = hs; e_flush = 1;
                    m_tag[hs][27] = 1'b0;
                end
            end
            3'd5: begin
                for (int i = 1; i < N; i++) begin
                    if (m_tag[i][27]) begin m_tag[i][27] = 1'b0; e_flush = 1; end
                end
            end
            default: e_err = 1;
        endcase
        @(negedge clk);
        req_valid = 1'b0;
        check_out(tag, 1'b1, e_err, e_hit, e_slot, e_data, e_flush);
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        check_out(tag, 1'b0, 1'b0, 1'b0, 0, 64'd0, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_desc[i] = '0; end
        repeat (3) @(negedge clk);
        check_out("R1", 1'b0, 1'b0, 1'b0, 0, 64'd0, 1'b0);
        rst = 1'b0;
        idle("R1");
        do_op(3'd0, 64'h0000_0000_0000_0000, 0, "R1");
        do_op(3'd2, 64'd5, 0, "R1");
        do_op(3'd3, 64'd5, 0, "R1");

        // 256 MB entry in slot 3, with junk in low bits to be stripped
        do_op(3'd1, 64'h1234_5670_0ABC_D003, 64'h0000_00AB_CDEF_0000, "R8");
        do_op(3'd2, 64'd3, 0, "R8");
        do_op(3'd3, 64'd3, 0, "R8");
        do_op(3'd0, 64'h1234_5670_0FFF_FFFF, 0, "R3");
        do_op(3'd0, 64'h1234_5680_0000_0000, 0, "R3");

        // size code checks
        large_seg_ok = 1'b0;
        do_op(3'd1, 64'hAAAA_BB00_0800_0004, 64'h4000_0000_0000_1111, "R7");
        do_op(3'd1, 64'h2222_0000_0800_0004, 64'h8000_0000_0000_0001, "R7");
        do_op(3'd1, 64'h2222_0000_0800_0004, 64'hC000_0000_0000_0001, "R7");
        do_op(3'd3, 64'd4, 0, "R7");
        large_seg_ok = 1'b1;
        do_op(3'd1, 64'hAAAA_BB00_0800_0004, 64'h4000_0000_0000_1111, "R4");
        do_op(3'd0, 64'hAAAA_BB12_3456_789A, 0, "R4");
        do_op(3'd0, 64'hAAAA_BC00_0000_0000, 0, "R4");
        // 1 TB entry whose tag has bits 39:28 set never matches
        do_op(3'd1, 64'h5555_0000_1800_0005, 64'h4000_0000_0000_2222, "R4");
        do_op(3'd0, 64'h5555_0000_1000_0000, 0, "R4");

        // duplicates: lowest slot wins
        do_op(3'd1, 64'h7777_0000_0800_0009, 64'h0000_0000_0000_0909, "R5");
        do_op(3'd1, 64'h7777_0000_0800_0007, 64'h0000_0000_0000_0707, "R5");
        do_op(3'd1, 64'h7777_0000_0800_0002, 64'h0000_0000_0000_0202, "R5");
        do_op(3'd0, 64'h7777_0000_0123_4567, 0, "R5");

        // slot range on store and read
        do_op(3'd1, 64'h3333_0000_0800_0010, 64'h0000_0000_0000_00EE, "R6");
        do_op(3'd1, 64'h3333_0000_0800_0800, 64'h0000_0000_0000_00EE, "R6");
        do_op(3'd2, 64'd0, 0, "R6");
        do_op(3'd0, 64'h3333_0000_0000_0000, 0, "R6");
        do_op(3'd2, 64'd16, 0, "R9");
        do_op(3'd3, 64'hFFF, 0, "R9");
        do_op(3'd3, 64'd15, 0, "R9");

        // slot 0 survives invalidate-all
        do_op(3'd1, 64'h0000_1000_0800_0000, 64'h0000_0000_0000_0ABC, "R10");
        idle("R13");
        do_op(3'd5, 0, 0, "R11");
        do_op(3'd0, 64'h0000_1000_0000_0000, 0, "R10");
        do_op(3'd0, 64'h1234_5670_0000_0000, 0, "R10");
        do_op(3'd2, 64'd4, 0, "R10");
        do_op(3'd5, 0, 0, "R11");

        // single invalidation
        do_op(3'd4, 64'h9999_0000_0000_0000, 0, "R12");
        do_op(3'd4, 64'h0000_1000_0FFF_0000, 0, "R12");
        do_op(3'd0, 64'h0000_1000_0000_0000, 0, "R12");
        do_op(3'd2, 64'd0, 0, "R12");

        // unknown codes
        do_op(3'd6, 64'h0000_1000_0000_0000, 0, "R2");
        do_op(3'd7, 0, 0, "R2");
        idle("R2");
        idle("R13");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule